// File: doc/BRIEF.md
# Asynchronous Static Memory Controller

This block turns 32-bit word requests from an on-chip host into timed cycles on a shared external bus. The bus serves static RAM, flash, PROM and memory-mapped peripherals behind four active-low chip selects. Each chip select has its own configuration word: device width, ready handling, and the lengths of the setup, strobe and hold phases. When the device is narrower than a word, the controller issues two or four back-to-back external cycles at ascending byte addresses. Read data is gathered little-endian into one 32-bit result.

Chip select 0 is the boot region. Until software writes its configuration, its device width comes from a 4-bit strap input, and its timing is the slowest setting. Any chip select can stretch its strobe phase with an active-low ready input, sampled either directly or through a two-stage synchronizer. A global timeout can cut short a wait for ready and report an error. Whenever the controller is not reading, it drives the data bus to all ones.

Top module: `async_mem_ctrl`

## Requirements
- R1: After reset, every chip select, strobe and byte enable is high, and `ready_o` is high. The data bus is driven (`mem_data_oe_o`=1) with all ones. Every chip select holds timing counts of 15, with ready handling off, and chip selects 1 to 3 are 32-bit.
- R2: A request is taken when `req_i` and `ready_o` are both high at a clock edge. The first setup cycle follows that edge. Each external cycle has three phases, with the selected chip select low throughout:
  - setup: S+1 cycles, both strobes high;
  - strobe: T+1 cycles;
  - hold: H+1 cycles, strobes high.
  S, T and H are configuration bits [11:8], [7:4] and [3:0]. `ack_o` is high for exactly the one cycle after the last hold, and `ready_o` is high in that cycle.
- R3: Configuration bits [15:14] select the device width:
  - 00: 8 bits, four cycles, byte enables 1110, data on lane [7:0];
  - 01: 16 bits, two cycles, byte enables 1100, data on [15:0];
  - 10 or 11: 32 bits, one cycle, byte enables 0000.
- R4: Only chip select `req_sel_i` goes low. In cycle k the address is `{req_addr_i,2'b00}` plus k for an 8-bit device or plus 2k for a 16-bit device.
- R5: On a write, cycle k carries byte k (8-bit device) or halfword k (16-bit device) of the write data, with unused lanes high. The data is driven during setup and strobe, then driven all ones during hold. `mem_wr_no` is low only in strobe.
- R6: On a read, `mem_rd_no` is low in strobe. The bus is released (`mem_data_oe_o`=0) from the first setup cycle until the last hold cycle ends. Each cycle's data is captured at the end of its strobe, and `rdata_o` holds the little-endian word while `ack_o` is high.
- R7: With configuration bit 13 set, the strobe phase continues past T+1 cycles until ready (`mem_rdy_ni`=0) is seen at a clock edge. With bit 12 clear, the pin is sampled at the edge itself. With bit 12 set, it is seen two edges later. With bit 13 clear, the pin has no effect.
- R8: With `tmo_en_i` high, suppose ready has still not been seen after `tmo_limit_i` extra strobe cycles. The strobe then ends after T+1+limit cycles, the hold runs, and the remaining cycles are skipped. `ack_o` then comes with `err_o`=1. Otherwise `err_o` stays 0.
- R9: Until chip select 0's configuration is written, its width follows the strap: 0000 gives 8 bits, 0001 gives 16 bits, and any other value gives 32 bits. After the write, the configured width is used.
- R10: A configuration write changes only the chip select addressed by `cfg_sel_i`.
- R11: At most one chip select is low at a time, and the read and write strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_strap_i | input | 4 | Boot width strap for chip select 0 |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Chip select addressed by the configuration write |
| cfg_data_i | input | 16 | Configuration word: width, ready enable, ready async, S, T, H |
| tmo_en_i | input | 1 | Ready timeout enable |
| tmo_limit_i | input | 8 | Extra strobe cycles allowed before a timeout |
| req_i | input | 1 | Host request |
| req_we_i | input | 1 | Host write (1) or read (0) |
| req_sel_i | input | 2 | Target chip select |
| req_addr_i | input | 22 | Word address inside the region |
| req_wdata_i | input | 32 | Host write data |
| ready_o | output | 1 | Controller idle, request can be taken |
| ack_o | output | 1 | Access complete pulse |
| err_o | output | 1 | Access ended by timeout, valid with ack_o |
| rdata_o | output | 32 | Assembled read data |
| mem_addr_o | output | 24 | External byte address |
| mem_cs_no | output | 4 | Chip selects, active low |
| mem_be_no | output | 4 | Byte lane enables, active low |
| mem_rd_no | output | 1 | Read strobe, active low |
| mem_wr_no | output | 1 | Write strobe, active low |
| mem_data_o | output | 32 | External data out |
| mem_data_oe_o | output | 1 | External data drive enable |
| mem_data_i | input | 32 | External data in |
| mem_rdy_ni | input | 1 | External ready, active low |

## Verification
The assertions assume three things about the inputs:
- configuration words are written only while `ready_o` is high, so the phase lengths and width of the access in flight never change underneath it;
- the strap is steady during an access;
- `mem_rdy_ni` changes only away from the clock edge.

The bench writes configuration and starts requests only in idle cycles, and moves the ready pin on falling edges. It holds the pin for two idle cycles before each access, so the synchronized copy starts from a known level.

// File: rtl/amc_pkg.sv
package amc_pkg;

  localparam int unsigned CNT_W = 4;
  localparam int unsigned CFG_W = 16;

  typedef struct packed {
    logic [1:0]       dw;        // 00: 8b, 01: 16b, 1x: 32b
    logic             rdy_en;
    logic             rdy_async;
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] strobe;
    logic [CNT_W-1:0] hold;
  } cs_cfg_t;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  localparam cs_cfg_t CFG_RST = '{dw: 2'b10, rdy_en: 1'b0, rdy_async: 1'b0,
                                  setup: '1, strobe: '1, hold: '1};

  function automatic logic [1:0] last_beat(input logic [1:0] dw);
    case (dw)
      2'b00:   return 2'd3;
      2'b01:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] strap_dw(input logic [3:0] strap);
    case (strap)
      4'b0000: return 2'b00;
      4'b0001: return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

endpackage

// File: rtl/amc_cfg_regs.sv
module amc_cfg_regs import amc_pkg::*; #(
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned SEL_W = $clog2(NUM_CS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  cs_cfg_t          cfg_i,
  input  logic [3:0]       boot_strap_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output cs_cfg_t          cfg_o
);

  cs_cfg_t regs_q [NUM_CS];
  logic    boot_ovr_q;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= CFG_RST;
      else if (cfg_we_i && cfg_sel_i == SEL_W'(g))   regs_q[g] <= cfg_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     boot_ovr_q <= 1'b0;
    else if (cfg_we_i && cfg_sel_i == '0)            boot_ovr_q <= 1'b1;
  end

  // boot region width follows the strap until software claims it
  always_comb begin
    cfg_o = regs_q[rd_sel_i];
    if (rd_sel_i == '0 && !boot_ovr_q) cfg_o.dw = strap_dw(boot_strap_i);
  end

endmodule

// File: rtl/amc_rdy_sync.sv
module amc_rdy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rdy_ni,
  input  logic async_i,
  output logic rdy_ok_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], rdy_ni};
  end

  assign rdy_ok_o = async_i ? ~sync_q[STAGES-1] : ~rdy_ni;

endmodule

// File: rtl/amc_seq.sv
module amc_seq import amc_pkg::*; #(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] setup_i,
  input  logic [CNT_W-1:0] strobe_i,
  input  logic [CNT_W-1:0] hold_i,
  input  logic             rdy_en_i,
  input  logic [1:0]       last_beat_i,
  input  logic             rdy_ok_i,
  input  logic             tmo_en_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  output phase_e           phase_o,
  output logic [1:0]       beat_o,
  output logic             cap_o,
  output logic             done_o,
  output logic             err_o
);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       beat_q;
  logic [TMO_W-1:0] wait_q;
  logic             abort_q, done_q, err_q;
  logic             min_done, waiting, tmo_hit, leave_stb;

  always_comb begin
    min_done  = (ph_q == PH_STROBE) && (cnt_q == '0);
    waiting   = min_done && rdy_en_i && !rdy_ok_i;
    tmo_hit   = waiting && tmo_en_i && (wait_q == tmo_limit_i);
    leave_stb = min_done && (!waiting || tmo_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      wait_q  <= '0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q    <= PH_SETUP;
          cnt_q   <= setup_i;
          beat_q  <= '0;
          abort_q <= 1'b0;
        end
        PH_SETUP: begin
          if (cnt_q == '0) begin
            ph_q   <= PH_STROBE;
            cnt_q  <= strobe_i;
            wait_q <= '0;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_STROBE: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (leave_stb) begin
            ph_q  <= PH_HOLD;
            cnt_q <= hold_i;
            if (tmo_hit) abort_q <= 1'b1;
          end else wait_q <= wait_q + 1'b1;
        end
        PH_HOLD: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (abort_q || beat_q == last_beat_i) begin
            ph_q   <= PH_IDLE;
            done_q <= 1'b1;
            err_q  <= abort_q;
          end else begin
            beat_q <= beat_q + 1'b1;
            ph_q   <= PH_SETUP;
            cnt_q  <= setup_i;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = ph_q;
  assign beat_o  = beat_q;
  assign cap_o   = leave_stb;
  assign done_o  = done_q;
  assign err_o   = err_q;

endmodule

// File: rtl/async_mem_ctrl.sv
module async_mem_ctrl import amc_pkg::*; #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned AW     = 24,
  parameter int unsigned TMO_W  = 8,
  localparam int unsigned SEL_W = $clog2(NUM_CS),
  localparam int unsigned WAW   = AW - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       boot_strap_i,
  input  logic             cfg_we_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  input  logic             tmo_en_i,
  input  logic [TMO_W-1:0] tmo_limit_i,
  input  logic             req_i,
  input  logic             req_we_i,
  input  logic [SEL_W-1:0] req_sel_i,
  input  logic [WAW-1:0]   req_addr_i,
  input  logic [31:0]      req_wdata_i,
  output logic             ready_o,
  output logic             ack_o,
  output logic             err_o,
  output logic [31:0]      rdata_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [NUM_CS-1:0] mem_cs_no,
  output logic [3:0]       mem_be_no,
  output logic             mem_rd_no,
  output logic             mem_wr_no,
  output logic [31:0]      mem_data_o,
  output logic             mem_data_oe_o,
  input  logic [31:0]      mem_data_i,
  input  logic             mem_rdy_ni
);

  phase_e           ph;
  logic [1:0]       beat;
  logic             start, cap, active, rdy_ok;
  logic             we_q;
  logic [SEL_W-1:0] sel_q, rd_sel;
  logic [WAW-1:0]   addr_q;
  logic [31:0]      wdata_q, rdata_q, lane;
  cs_cfg_t          cfg;

  assign ready_o = (ph == PH_IDLE);
  assign start   = req_i & ready_o;
  assign rd_sel  = ready_o ? req_sel_i : sel_q;
  assign active  = !ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      sel_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      we_q    <= req_we_i;
      sel_q   <= req_sel_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  amc_cfg_regs #(.NUM_CS(NUM_CS)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i,
    .cfg_i        (cs_cfg_t'(cfg_data_i)),
    .boot_strap_i,
    .rd_sel_i     (rd_sel),
    .cfg_o        (cfg)
  );

  amc_rdy_sync #(.STAGES(2)) u_rdy (
    .clk_i, .rst_ni,
    .rdy_ni   (mem_rdy_ni),
    .async_i  (cfg.rdy_async),
    .rdy_ok_o (rdy_ok)
  );

  amc_seq #(.TMO_W(TMO_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i     (start),
    .setup_i     (cfg.setup),
    .strobe_i    (cfg.strobe),
    .hold_i      (cfg.hold),
    .rdy_en_i    (cfg.rdy_en),
    .last_beat_i (last_beat(cfg.dw)),
    .rdy_ok_i    (rdy_ok),
    .tmo_en_i,
    .tmo_limit_i,
    .phase_o     (ph),
    .beat_o      (beat),
    .cap_o       (cap),
    .done_o      (ack_o),
    .err_o       (err_o)
  );

  always_comb begin
    mem_cs_no  = '1;
    mem_be_no  = '1;
    mem_addr_o = {addr_q, 2'b00};
    lane       = wdata_q;
    if (active) begin
      mem_cs_no[sel_q] = 1'b0;
      case (cfg.dw)
        2'b00: begin
          mem_be_no       = 4'b1110;
          mem_addr_o[1:0] = beat;
          lane            = {24'hFF_FFFF, wdata_q[{beat, 3'b000} +: 8]};
        end
        2'b01: begin
          mem_be_no       = 4'b1100;
          mem_addr_o[1:0] = {beat[0], 1'b0};
          lane            = {16'hFFFF, wdata_q[{beat[0], 4'b0000} +: 16]};
        end
        default: mem_be_no = 4'b0000;
      endcase
    end
    mem_rd_no     = !(ph == PH_STROBE && !we_q);
    mem_wr_no     = !(ph == PH_STROBE && we_q);
    mem_data_oe_o = !(active && !we_q);
    // bus parks high once the write strobe has ended
    mem_data_o    = (active && we_q && ph != PH_HOLD) ? lane : '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (cap && !we_q) begin
      case (cfg.dw)
        2'b00:   rdata_q[{beat, 3'b000} +: 8]     <= mem_data_i[7:0];
        2'b01:   rdata_q[{beat[0], 4'b0000} +: 16] <= mem_data_i[15:0];
        default: rdata_q <= mem_data_i;
      endcase
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/amc_chk.sv
module amc_chk #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned AW     = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CS-1:0] mem_cs_no,
  input logic              mem_rd_no,
  input logic              mem_wr_no,
  input logic              mem_data_oe_o,
  input logic [31:0]       mem_data_o,
  input logic [AW-1:0]     mem_addr_o,
  input logic              ready_o,
  input logic              ack_o,
  input logic              err_o
);

  // R11
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no));

  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_rd_no && !mem_wr_no));

  // R2
  strobe_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_rd_no || !mem_wr_no) |-> (mem_cs_no != '1));

  // R2
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R6
  rd_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rd_no |-> !mem_data_oe_o);

  // R5
  wr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_wr_no && $past(!mem_wr_no)) |-> ($stable(mem_data_o) && $stable(mem_addr_o)));

  // R8
  err_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ack_o);

  // R1
  idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (mem_cs_no == '1 && mem_data_oe_o && mem_data_o == '1));

endmodule

bind async_mem_ctrl amc_chk #(.NUM_CS(NUM_CS), .AW(AW)) u_chk (
  .clk_i, .rst_ni, .mem_cs_no, .mem_rd_no, .mem_wr_no, .mem_data_oe_o,
  .mem_data_o, .mem_addr_o, .ready_o, .ack_o, .err_o
);

// File: tb/async_mem_ctrl_tb.sv
`timescale 1ns/1ps
module async_mem_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  strap;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_data;
  logic        tmo_en;
  logic [7:0]  tmo_lim;
  logic        req, req_we;
  logic [1:0]  req_sel;
  logic [21:0] req_addr;
  logic [31:0] req_wdata;
  logic        ready_o, ack_o, err_o;
  logic [31:0] rdata_o;
  logic [23:0] mem_addr;
  logic [3:0]  mem_cs_n, mem_be_n;
  logic        mem_rd_n, mem_wr_n, mem_oe;
  logic [31:0] mem_dout, mem_din;
  logic        mem_rdy_n;

  always #2.5 clk = ~clk;

  async_mem_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .boot_strap_i(strap),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .tmo_en_i(tmo_en), .tmo_limit_i(tmo_lim),
    .req_i(req), .req_we_i(req_we), .req_sel_i(req_sel), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .ready_o(ready_o), .ack_o(ack_o), .err_o(err_o),
    .rdata_o(rdata_o), .mem_addr_o(mem_addr), .mem_cs_no(mem_cs_n),
    .mem_be_no(mem_be_n), .mem_rd_no(mem_rd_n), .mem_wr_no(mem_wr_n),
    .mem_data_o(mem_dout), .mem_data_oe_o(mem_oe), .mem_data_i(mem_din),
    .mem_rdy_ni(mem_rdy_n)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  // device model: byte at address a sits on lane (a - mem_addr)
  always_comb mem_din = {pat(mem_addr + 24'd3), pat(mem_addr + 24'd2),
                         pat(mem_addr + 24'd1), pat(mem_addr)};

  logic [12:0] ctl;
  assign ctl = {mem_cs_n, mem_be_n, mem_rd_n, mem_wr_n, mem_oe, ready_o, ack_o};

  int errs = 0, checks = 0;
  bit finished = 0;
  int m_dw[4], m_s[4], m_t[4], m_h[4], m_ren[4], m_ras[4];
  bit ovr = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic set_cfg(input int sel, input int dw, input int ren, input int ras,
                         input int s, input int t, input int h);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_sel  = 2'(sel);
    cfg_data = {2'(dw), 1'(ren), 1'(ras), 4'(s), 4'(t), 4'(h)};
    @(negedge clk);
    cfg_we = 1'b0;
    m_dw[sel] = dw; m_s[sel] = s; m_t[sel] = t; m_h[sel] = h;
    m_ren[sel] = ren; m_ras[sel] = ras;
    if (sel == 0) ovr = 1;
  endtask

  // behavioural per-cycle model of one host access
  task automatic access(input int sel, input bit we, input logic [21:0] wa,
                        input logic [31:0] wd, input int rdy_at, input string rq);
    int dw, nb, s, t, h, ren, ras, n, ph, cnt, beat, wt;
    bit abort, fin, okv;
    logic [23:0] ea;
    logic [23:0] base;
    logic [3:0]  be;
    logic [31:0] lane, exp_word;
    logic [12:0] exp;
    dw  = (sel == 0 && !ovr) ? ((strap == 4'd0) ? 0 : (strap == 4'd1) ? 1 : 2) : m_dw[sel];
    nb  = (dw == 0) ? 4 : (dw == 1) ? 2 : 1;
    s = m_s[sel]; t = m_t[sel]; h = m_h[sel]; ren = m_ren[sel]; ras = m_ras[sel];
    base = {wa, 2'b00};
    @(negedge clk);
    mem_rdy_n = (0 >= rdy_at) ? 1'b0 : 1'b1;
    @(negedge clk);
    @(negedge clk);
    req = 1'b1; req_we = we; req_sel = 2'(sel); req_addr = wa; req_wdata = wd;
    chk(ready_o === 1'b1, {rq, " R2 ready before request"}, 32'(ready_o), 32'd1);
    @(negedge clk);
    req = 1'b0; req_addr = '0; req_wdata = '0; req_sel = '0;
    n = 1; ph = 0; cnt = 0; beat = 0; wt = 0; abort = 0; fin = 0;
    while (!fin) begin
      mem_rdy_n = (n >= rdy_at) ? 1'b0 : 1'b1;
      ea   = base + 24'((dw == 0) ? beat : (dw == 1) ? 2 * beat : 0);
      be   = (dw == 0) ? 4'b1110 : (dw == 1) ? 4'b1100 : 4'b0000;
      lane = (dw == 0) ? {24'hFFFFFF, wd[8*beat +: 8]} :
             (dw == 1) ? {16'hFFFF, wd[16*beat +: 16]} : wd;
      exp  = {~(4'b0001 << sel), be, !(ph == 1 && !we), !(ph == 1 && we), we, 1'b0, 1'b0};
      chk(ctl == exp, {rq, " R2 R3 R6 control pins"}, 32'(ctl), 32'(exp));
      chk(mem_addr == ea, {rq, " R4 address"}, 32'(mem_addr), 32'(ea));
      chk($countones(~mem_cs_n) <= 1 && (mem_rd_n || mem_wr_n), {rq, " R11 exclusivity"},
          32'(ctl), 32'(exp));
      if (we) chk(mem_dout == ((ph != 2) ? lane : 32'hFFFF_FFFF), {rq, " R5 write data"},
                  mem_dout, (ph != 2) ? lane : 32'hFFFF_FFFF);
      cnt++;
      case (ph)
        0: if (cnt == s + 1) begin ph = 1; cnt = 0; wt = 0; end
        1: if (cnt >= t + 1) begin
             okv = ras ? (n - 2 >= rdy_at) : (n >= rdy_at);
             if (!ren || okv) begin ph = 2; cnt = 0; end
             else if (tmo_en && wt == int'(tmo_lim)) begin abort = 1; ph = 2; cnt = 0; end
             else wt++;
           end
        default: if (cnt == h + 1) begin
             if (abort || beat == nb - 1) fin = 1;
             else begin beat++; ph = 0; cnt = 0; end
           end
      endcase
      n++;
      @(negedge clk);
    end
    chk(ctl == 13'b1111_1111_11111, {rq, " R2 ack cycle idle pins"}, 32'(ctl), 32'h1FFF);
    chk(err_o == abort, {rq, " R8 error flag"}, 32'(err_o), 32'(abort));
    exp_word = {pat(base + 24'd3), pat(base + 24'd2), pat(base + 24'd1), pat(base)};
    if (!we && !abort) chk(rdata_o == exp_word, {rq, " R6 read word"}, rdata_o, exp_word);
    @(negedge clk);
    chk(ack_o == 1'b0, {rq, " R2 single ack"}, 32'(ack_o), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_dw[i] = 2; m_s[i] = 15; m_t[i] = 15; m_h[i] = 15; m_ren[i] = 0; m_ras[i] = 0;
    end
    rst_n = 1'b0; strap = 4'b0001; cfg_we = 0; cfg_sel = 0; cfg_data = 0;
    tmo_en = 0; tmo_lim = 8'd3; req = 0; req_we = 0; req_sel = 0; req_addr = 0;
    req_wdata = 0; mem_rdy_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctl == 13'b1111_1111_11110, "R1 reset pins", 32'(ctl), 32'h1FFE);
    chk(mem_dout == 32'hFFFF_FFFF, "R1 reset bus high", mem_dout, 32'hFFFF_FFFF);

    // boot region: strap-selected width, slowest timing
    access(0, 1'b0, 22'h01_2345, 32'h0, 1000, "R9 R1 boot 16b read");
    strap = 4'b0000;
    access(0, 1'b1, 22'h00_0100, 32'hA1B2_C3D4, 1000, "R9 R5 boot 8b write");

    set_cfg(1, 1, 0, 0, 1, 2, 0);
    access(1, 1'b1, 22'h3F_0001, 32'h1122_3344, 1000, "R3 R5 cs1 16b write");
    access(1, 1'b0, 22'h2A_5555, 32'h0, 1000, "R3 R6 cs1 16b read");

    set_cfg(2, 3, 0, 0, 0, 0, 1);
    access(2, 1'b1, 22'h15_AAAA, 32'hDEAD_BEEF, 1000, "R3 R7 cs2 32b write ready ignored");
    access(2, 1'b0, 22'h00_0F0F, 32'h0, 1000, "R3 R6 cs2 32b read");

    set_cfg(3, 0, 0, 0, 2, 1, 2);
    access(3, 1'b0, 22'h07_7777, 32'h0, 1000, "R3 R4 cs3 8b read");
    access(3, 1'b1, 22'h07_7778, 32'h5A6B_7C8D, 1000, "R3 R5 cs3 8b write");

    set_cfg(1, 2, 1, 0, 0, 1, 0);
    access(1, 1'b0, 22'h12_3456, 32'h0, 6, "R7 sync ready late");
    set_cfg(2, 2, 1, 1, 0, 0, 0);
    access(2, 1'b0, 22'h23_4567, 32'h0, 4, "R7 async ready late");

    tmo_en = 1'b1;
    set_cfg(3, 0, 1, 0, 1, 1, 1);
    access(3, 1'b0, 22'h0A_0A0A, 32'h0, 1000, "R8 timeout read");
    access(3, 1'b1, 22'h0B_0B0B, 32'hCAFE_F00D, 1000, "R8 timeout write");
    access(3, 1'b0, 22'h0C_0C0C, 32'h0, 5, "R8 ready within limit");
    tmo_en = 1'b0;
    access(3, 1'b0, 22'h0D_0D0D, 32'h0, 15, "R8 long wait without timeout");

    set_cfg(0, 2, 0, 0, 0, 0, 0);
    access(0, 1'b0, 22'h33_3333, 32'h0, 1000, "R9 boot width overridden");
    access(1, 1'b0, 22'h01_0101, 32'h0, -10, "R10 cs1 config untouched");
    access(2, 1'b1, 22'h02_0202, 32'h0BAD_F00D, -10, "R10 cs2 config untouched");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule